// File: doc/BRIEF.md
# Dynamic Bus Width Sizing Controller

This block connects a 32-bit requester to an external bus whose width may be 8, 16 or 32 bits and may change from one bus cycle to the next. The requester hands over one transfer with four active-low byte enables. The block then runs one or more bus cycles. In each cycle it reports a 4-bit mask of the byte lanes that carry valid data. Two active-low size pins set the width of each cycle. The block samples them on every clock and uses the value captured on the edge before the ready strobe.

When a cycle ends, the block drops the lanes just moved from its pending set. If bytes remain, a new bus cycle starts at once with the remaining enables. When the last byte has moved, the block raises a one-cycle completion pulse. Read bytes from every cycle are collected into one 32-bit word. A request with no byte enabled is illegal: it completes at once with an error flag and runs no bus cycle.

Top module: `bus_width_sizer`

## Requirements
- R1: The width used for a bus cycle is the one given by the size pins at the clock edge before the edge where `rdy_n` is sampled low. A change on the size pins during the clock in which `rdy_n` is low does not alter that cycle's `lane_valid`.
- R2: If `bs8_n` is low, the cycle is 8 bits wide, whatever `bs16_n` is. If only `bs16_n` is low, the cycle is 16 bits wide. If both pins are high, the cycle is 32 bits wide.
- R3: In a 32-bit cycle, `lane_valid` equals the set of pending enabled bytes. Bit i of `lane_valid` stands for data bits 8i+7..8i, and bit i of `req_be_n` and `cyc_be_n` enables byte i when low.
- R4: In a 16-bit cycle, `lane_valid` holds the pending bytes that lie in the same half (lanes 0-1 or lanes 2-3) as the lowest-numbered pending byte.
- R5: In an 8-bit cycle, `lane_valid` holds only the lowest-numbered pending byte.
- R6: On a clock edge with `cyc_active` high and `rdy_n` low, the lanes in `lane_valid` are removed from the pending set. If any byte remains, `cyc_active` stays high and `cyc_be_n` shows the remaining enables from the next cycle on.
- R7: `done` is high for exactly the one cycle after the edge that removes the last pending byte. In that cycle `cyc_active` is low.
- R8: For a read (`req_write` low), `rd_data` holds, from the `done` cycle on, each enabled byte as it was on `bus_rdata` at the edge that moved it. Bytes that were not enabled read as zero.
- R9: A request with `req_be_n` = 4'b1111 makes `done` and `err` high in the next cycle, and no bus cycle starts (`cyc_active` stays low).
- R10: `req_valid` is ignored while `cyc_active` is high. The pending enables shown on `cyc_be_n` do not change because of it.
- R11: After reset, `cyc_active`, `done` and `err` are low, `lane_valid` is zero and `cyc_be_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be_n | input | 4 | Byte enables of the request, active low |
| bs8_n | input | 1 | Size pin for an 8-bit cycle, active low |
| bs16_n | input | 1 | Size pin for a 16-bit cycle, active low |
| rdy_n | input | 1 | Bus cycle ready, active low |
| bus_rdata | input | 32 | Read data from the external bus |
| cyc_active | output | 1 | A bus cycle is in progress |
| cyc_be_n | output | 4 | Pending enables of the current cycle, active low |
| lane_valid | output | 4 | Valid byte lanes of the current cycle, active high |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal empty request, pulses with done |
| rd_data | output | 32 | Merged read word |

## Verification
The assertions assume that `rdy_n` matters only while `cyc_active` is high, and that a new request arrives only when the block is idle. They also assume that whatever lies on the size pins one edge before ready is the width the bus really used. The stimulus changes every input only at falling clock edges. It holds the size pins steady through each wait clock, so the sampled width is always known. It then deliberately moves the pins during each ready clock, which checks that they are ignored there. It re-drives `req_valid` only during wait clocks, when the block must discard it.

// File: rtl/bws_pkg.sv
package bws_pkg;

    // Width of one external bus cycle, ordered from narrow to wide.
    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2
    } bus_wid_e;

    // Fixed priority: 8-bit request wins over 16-bit, otherwise full width.
    function automatic bus_wid_e decode_width(input logic narrow8_n, input logic narrow16_n);
        if (!narrow8_n) begin
            return WID_8;
        end else if (!narrow16_n) begin
            return WID_16;
        end
        return WID_32;
    endfunction

endpackage

// File: rtl/bws_size_sync.sv
module bws_size_sync
    import bws_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bs8_n,
    input  logic     bs16_n,
    output bus_wid_e width_q
);

    bus_wid_e width_d;

    always_comb begin
        width_d = decode_width(bs8_n, bs16_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= WID_32;
        end else begin
            width_q <= width_d;
        end
    end

endmodule

// File: rtl/bws_lane_pick.sv
module bws_lane_pick
    import bws_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] pend,
    input  bus_wid_e         width,
    output logic [LANES-1:0] lanes
);

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int HALVES = LANES / 2;

    logic [IDX_W-1:0] low_idx;
    logic [LANES-1:0] low_hot;
    logic [LANES-1:0] half_mask;

    // Lowest pending lane: scan from the top so the lowest set bit wins.
    always_comb begin
        low_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        low_hot = '0;
        low_hot[low_idx] = pend[low_idx];
    end

    // Each pair of lanes forms one 16-bit half.
    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_half
            logic in_half;
            assign in_half = (int'(low_idx) / 2) == h;
            assign half_mask[2*h]   = in_half;
            assign half_mask[2*h+1] = in_half;
        end
        if (LANES % 2 != 0) begin : g_odd
            assign half_mask[LANES-1] = (int'(low_idx) == LANES - 1);
        end
    endgenerate

    always_comb begin
        unique case (width)
            WID_8:   lanes = low_hot;
            WID_16:  lanes = pend & half_mask;
            default: lanes = pend;
        endcase
    end

endmodule

// File: rtl/bws_rd_merge.sv
module bws_rd_merge #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] asm_q
);

    localparam int BYTE_W = DATA_W / LANES;

    logic [DATA_W-1:0] asm_d;

    always_comb begin
        asm_d = asm_q;
        if (clear) begin
            asm_d = '0;
        end else if (capture) begin
            for (int i = 0; i < LANES; i++) begin
                if (lanes[i]) begin
                    asm_d[i*BYTE_W +: BYTE_W] = bus_rdata[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

endmodule

// File: rtl/bus_width_sizer.sv
module bus_width_sizer
    import bws_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_be_n,
    input  logic              bs8_n,
    input  logic              bs16_n,
    input  logic              rdy_n,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cyc_active,
    output logic [LANES-1:0]  cyc_be_n,
    output logic [LANES-1:0]  lane_valid,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic             active;
        logic             write;
        logic [LANES-1:0] pend;
        logic             done;
        logic             err;
    } seq_t;

    seq_t             st_d;
    seq_t             st_q;
    bus_wid_e         width_q;
    logic [LANES-1:0] lanes;
    logic             accept;
    logic             cyc_end;

    bws_size_sync i_size (
        .clk     (clk),
        .rst_n   (rst_n),
        .bs8_n   (bs8_n),
        .bs16_n  (bs16_n),
        .width_q (width_q)
    );

    bws_lane_pick #(.LANES(LANES)) i_pick (
        .pend  (st_q.pend),
        .width (width_q),
        .lanes (lanes)
    );

    assign accept  = !st_q.active && req_valid;
    assign cyc_end = st_q.active && !rdy_n;

    bws_rd_merge #(.LANES(LANES), .DATA_W(DATA_W)) i_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (cyc_end && !st_q.write),
        .lanes     (lanes),
        .bus_rdata (bus_rdata),
        .asm_q     (rd_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (accept) begin
            if (&req_be_n) begin
                st_d.done = 1'b1;
                st_d.err  = 1'b1;
            end else begin
                st_d.active = 1'b1;
                st_d.write  = req_write;
                st_d.pend   = ~req_be_n;
            end
        end else if (cyc_end) begin
            st_d.pend = st_q.pend & ~lanes;
            if (st_d.pend == '0) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_active = st_q.active;
    assign cyc_be_n   = st_q.active ? ~st_q.pend : '1;
    assign lane_valid = st_q.active ? lanes : '0;
    assign done       = st_q.done;
    assign err        = st_q.err;

endmodule

// File: rtl/bws_checker.sv
module bws_checker
    import bws_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rdy_n,
    input logic             cyc_active,
    input logic [LANES-1:0] cyc_be_n,
    input logic [LANES-1:0] lane_valid,
    input logic             done,
    input logic             err,
    input bus_wid_e         width
);

    a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && width == WID_8) |-> $countones(lane_valid) == 1);

    a_r3_all_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && width == WID_32) |-> lane_valid == ~cyc_be_n);

    a_r4_lanes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_active |-> ((lane_valid & cyc_be_n) == '0 && lane_valid != '0));

    a_r6_remaining: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && !rdy_n && lane_valid != ~cyc_be_n)
        |=> (cyc_active && cyc_be_n == ($past(cyc_be_n) | $past(lane_valid))));

    a_r7_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && !rdy_n && lane_valid == ~cyc_be_n) |=> (done && !err && !cyc_active));

    a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !cyc_active));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_active |-> (lane_valid == '0 && cyc_be_n == '1));

endmodule

bind bus_width_sizer bws_checker #(.LANES(LANES)) i_bws_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_n      (rdy_n),
    .cyc_active (cyc_active),
    .cyc_be_n   (cyc_be_n),
    .lane_valid (lane_valid),
    .done       (done),
    .err        (err),
    .width      (width_q)
);

// File: tb/test_bus_width_sizer.sv
module test_bus_width_sizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be_n = 4'hF;
    logic        bs8_n = 1'b1;
    logic        bs16_n = 1'b1;
    logic        rdy_n = 1'b1;
    logic [31:0] bus_rdata = '0;
    logic        cyc_active;
    logic [3:0]  cyc_be_n;
    logic [3:0]  lane_valid;
    logic        done;
    logic        err;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_width_sizer i_bus_width_sizer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_be_n   (req_be_n),
        .bs8_n      (bs8_n),
        .bs16_n     (bs16_n),
        .rdy_n      (rdy_n),
        .bus_rdata  (bus_rdata),
        .cyc_active (cyc_active),
        .cyc_be_n   (cyc_be_n),
        .lane_valid (lane_valid),
        .done       (done),
        .err        (err),
        .rd_data    (rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected lanes computed from the requirement text: mode 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
    function automatic logic [3:0] model_lanes(input logic [3:0] p, input int m);
        int lo = 0;
        for (int i = 3; i >= 0; i--) if (p[i]) lo = i;
        if (m == 0) return 4'(1 << lo);
        if (m == 1) return p & (4'b0011 << ((lo / 2) * 2));
        return p;
    endfunction

    // Drive the size pins for a mode; 8-bit mode sometimes also asserts the 16-bit pin (R2).
    task automatic set_pins(input int m, input bit both);
        bs8_n  = (m == 0) ? 1'b0 : 1'b1;
        bs16_n = (m == 1) ? 1'b0 : ((m == 0) ? ~both : 1'b1);
    endtask

    function automatic string lane_req(input int m);
        if (m == 0) return "R5+R2+R1";
        if (m == 1) return "R4+R2+R1";
        return "R3+R2+R1";
    endfunction

    // sel 0..2: fixed width, 3: width rotates per cycle.
    task automatic run_req(input logic [3:0] be_n, input bit wr, input int sel);
        logic [3:0]  pend = ~be_n;
        logic [31:0] exp_asm = '0;
        logic [3:0]  lv;
        int          cyc = 0;
        int          m;
        @(negedge clk);
        m = (sel < 3) ? sel : (be_n % 3);
        set_pins(m, be_n[0]);
        req_valid = 1'b1;
        req_write = wr;
        req_be_n  = be_n;
        rdy_n     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (be_n == 4'hF) begin
            chk(done && err && !cyc_active, "R9", {29'd0, done, err, cyc_active}, 32'h6);
            return;
        end
        while (pend != 4'h0) begin
            lv = model_lanes(pend, m);
            chk(cyc_active && cyc_be_n == ~pend, "R6+R10", {27'd0, cyc_active, cyc_be_n}, {27'd0, 1'b1, ~pend});
            chk(lane_valid == lv, lane_req(m), {28'd0, lane_valid}, {28'd0, lv});
            req_valid = 1'b0;
            rdy_n     = 1'b0;
            bus_rdata = 32'h1E2D3C4B + cyc * 32'h11111111 + {28'd0, be_n};
            // Disturb the pins during the ready clock: must have no effect (R1).
            set_pins((m == 2) ? 0 : 2, 1'b0);
            for (int k = 0; k < 4; k++) if (lv[k]) exp_asm[k*8 +: 8] = bus_rdata[k*8 +: 8];
            @(posedge clk);
            @(negedge clk);
            pend  = pend & ~lv;
            cyc++;
            rdy_n = 1'b1;
            if (pend != 4'h0) begin
                chk(!done && cyc_active, "R6", {30'd0, done, cyc_active}, 32'h1);
                m = (sel < 3) ? sel : ((cyc + be_n) % 3);
                set_pins(m, cyc[0]);
                // Request offered during a wait clock must be dropped (R10).
                req_valid = 1'b1;
                req_be_n  = ~be_n;
                @(posedge clk);
                @(negedge clk);
            end
        end
        chk(done && !err && !cyc_active, "R7", {29'd0, done, err, cyc_active}, 32'h4);
        if (!wr) chk(rd_data == exp_asm, "R8", rd_data, exp_asm);
        @(negedge clk);
        chk(!done, "R7", {31'd0, done}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cyc_active && !done && !err && lane_valid == 4'h0 && cyc_be_n == 4'hF, "R11",
            {21'd0, cyc_active, done, err, lane_valid, cyc_be_n}, {27'd0, 4'hF});
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cyc_active && !done && lane_valid == 4'h0, "R11", {28'd0, lane_valid}, 32'h0);
        for (int sel = 0; sel < 4; sel++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int be = 0; be < 16; be++) begin
                    run_req(4'(be), wr[0], sel);
                end
            end
        end
        // Empty request followed straight by a legal one: the second must run normally.
        run_req(4'hF, 1'b0, 2);
        run_req(4'h6, 1'b0, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule